// File: doc/BRIEF.md
# Programmable Multi-Line Edge Detector

The block watches a bus of 256 single-bit monitor lines and samples every line on each clock. For each line it keeps the previous sample. When the transition selected for that line occurs, it emits a one-cycle event pulse on the matching bit of a 256-bit event output. Each line can look for a rising edge, a falling edge or either edge. A per-line mask bit can silence the line.

Software sets the block up through a simple register port with byte address, write data, write strobe and registered read data. The per-line edge modes are held two bits per line in sixteen 32-bit words. The per-line mask bits are held one bit per line in eight 32-bit words. A single enable bit turns detection on and off. While detection is off, the previous-sample registers keep following the inputs. Turning detection on therefore never reports a transition that happened while it was off.

Top module: `edet_top`

## Requirements
- R1: After a synchronous active-low reset, all mode words, all mask words and the enable bit read as zero, and the event output and the read data are all zero.
- R2: Mode code 00 selects rising edges. Line i takes its mode from word i/16, bits [2*(i%16)+1 : 2*(i%16)]. A line sampled 0 on one clock edge and 1 on the next produces an event pulse on `evt_out[i]` that is visible right after that second edge.
- R3: Mode code 01 selects falling edges: a 1 followed by a 0 on consecutive samples gives a pulse with the same timing as R2.
- R4: Mode code 10 selects both edges: any change between consecutive samples gives a pulse.
- R5: Mode code 11 is reserved, and a line in this mode never produces an event.
- R6: Mask word n sits at byte address 0x848 + 4*n, for n from 0 to 7. Line i uses bit i%32 of word i/32. A mask bit of 1 suppresses events on that line, and a mask bit of 0 lets them through.
- R7: Bit 0 of the enable register at byte address 0x780 gates detection. While it is 0 no events appear. The previous samples keep following the inputs, so turning detection on produces no event for a change made while detection was off. Writes to bits 31:1 of this register have no effect.
- R8: Mode word n sits at byte address 0x808 + 4*n, for n from 0 to 15. A read returns the last value written to the word, with one cycle of latency. A read of the enable register returns the enable in bit 0 and zeros in bits 31:1.
- R9: An address that selects no word reads as zero, and a write to it changes nothing. This covers any address whose two low bits are not 00.
- R10: Each detected transition gives exactly one single-cycle pulse. A level held steady after an edge produces no further events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe for the addressed word |
| reg_rdata | output | 32 | Read data for the address presented on the previous clock |
| mon_in | input | 256 | Monitored lines |
| evt_out | output | 256 | One-cycle event pulse per line |

## Verification
The bench drives new inputs at each falling edge. An event is due at the next falling edge, because the rising edge in between both samples the new line level and registers the comparison with the old one. Read data for an address is due at that same falling edge. The bench model computes the expected events and read data from the mode, mask and enable state as it stood before that rising edge. A write applied in the same step only affects the following step. Both outputs are compared on every cycle under the tag of the requirement the phase exercises.

// File: rtl/edet_pkg.sv
// Package: shared mode encoding and register byte offsets for the edge detector.
// Assumes a byte-addressed register port with 32-bit word-aligned registers.
package edet_pkg;

    typedef enum logic [1:0] {
        MODE_RISE = 2'b00,
        MODE_FALL = 2'b01,
        MODE_BOTH = 2'b10,
        MODE_RSVD = 2'b11
    } edge_mode_e;

    localparam int ENABLE_OFS = 'h780;
    localparam int CTRL_BASE  = 'h808;
    localparam int MASK_BASE  = 'h848;

endpackage

// File: rtl/edet_regbank.sv
// Register bank: holds the enable bit, the packed mode words and the packed mask words.
// It decodes a byte address, applies writes and returns registered read data.
// Assumes word-aligned accesses. Any other address decodes to no register.
module edet_regbank
    import edet_pkg::*;
#(
    parameter int NUM_LINES = 256,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [DATA_W-1:0]      reg_wdata,
    input  logic                   reg_we,
    output logic [DATA_W-1:0]      reg_rdata,
    output logic [2*NUM_LINES-1:0] mode_flat,
    output logic [NUM_LINES-1:0]   mask_flat,
    output logic                   det_en
);
    localparam int MODES_PER_WORD = DATA_W / 2;
    localparam int N_CTRL = NUM_LINES / MODES_PER_WORD;
    localparam int N_MASK = NUM_LINES / DATA_W;
    localparam int WA_W   = ADDR_W - 2;
    localparam int CIDX_W = (N_CTRL > 1) ? $clog2(N_CTRL) : 1;
    localparam int MIDX_W = (N_MASK > 1) ? $clog2(N_MASK) : 1;
    localparam logic [WA_W-1:0] EN_WA   = WA_W'(ENABLE_OFS >> 2);
    localparam logic [WA_W-1:0] CTRL_WA = WA_W'(CTRL_BASE >> 2);
    localparam logic [WA_W-1:0] MASK_WA = WA_W'(MASK_BASE >> 2);
    localparam logic [WA_W-1:0] N_CTRL_W = WA_W'(N_CTRL);
    localparam logic [WA_W-1:0] N_MASK_W = WA_W'(N_MASK);

    logic [DATA_W-1:0] ctrl_q [N_CTRL];
    logic [DATA_W-1:0] mask_q [N_MASK];
    logic              en_q;
    logic [DATA_W-1:0] rd_next;
    logic [DATA_W-1:0] rdata_q;

    logic              aligned;
    logic [WA_W-1:0]   wa, c_off, m_off;
    logic              en_hit, c_hit, m_hit, any_hit;
    logic [CIDX_W-1:0] c_idx;
    logic [MIDX_W-1:0] m_idx;

    // Address decode: word address, offsets into each bank, hit flags.
    always_comb begin
        aligned = (reg_addr[1:0] == 2'b00);
        wa      = reg_addr[ADDR_W-1:2];
        c_off   = wa - CTRL_WA;
        m_off   = wa - MASK_WA;
        en_hit  = aligned && (wa == EN_WA);
        c_hit   = aligned && (c_off < N_CTRL_W);
        m_hit   = aligned && (m_off < N_MASK_W);
        any_hit = en_hit || c_hit || m_hit;
        c_idx   = c_off[CIDX_W-1:0];
        m_idx   = m_off[MIDX_W-1:0];
    end

    // Enable register: only bit 0 of the write data is kept.
    always_ff @(posedge clk) begin
        if (!rst_n)                en_q <= 1'b0;
        else if (reg_we && en_hit) en_q <= reg_wdata[0];
    end

    generate
        for (genvar n = 0; n < N_CTRL; n++) begin : g_ctrl
            // Mode word n: written when its offset is addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)                                     ctrl_q[n] <= '0;
                else if (reg_we && c_hit && c_idx == CIDX_W'(n)) ctrl_q[n] <= reg_wdata;
            end
            assign mode_flat[n*DATA_W +: DATA_W] = ctrl_q[n];
        end
        for (genvar n = 0; n < N_MASK; n++) begin : g_mask
            // Mask word n: written when its offset is addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)                                     mask_q[n] <= '0;
                else if (reg_we && m_hit && m_idx == MIDX_W'(n)) mask_q[n] <= reg_wdata;
            end
            assign mask_flat[n*DATA_W +: DATA_W] = mask_q[n];
        end
    endgenerate

    // Read mux: selected word, or zero for addresses that select no word.
    always_comb begin
        rd_next = '0;
        if (en_hit)     rd_next[0] = en_q;
        else if (c_hit) rd_next    = ctrl_q[c_idx];
        else if (m_hit) rd_next    = mask_q[m_idx];
    end

    // Read data register: one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rd_next;
    end

    assign reg_rdata = rdata_q;
    assign det_en    = en_q;

    // R9: a read of an address that selects no word returns zero.
    a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!any_hit) |-> (rdata_q == '0));

    // R7: the enable changes only through a write to the register port.
    a_r7_enable_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(en_q) |-> $past(reg_we));

endmodule

// File: rtl/edet_line_cell.sv
// Line cell: one monitored line. It holds the previous sample, picks the transition
// selected by the line's mode, and registers a one-cycle event gated by enable and mask.
// Assumes mon input is synchronous to clk.
module edet_line_cell
    import edet_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample,
    input  logic [1:0] mode,
    input  logic       mask_bit,
    input  logic       det_en,
    output logic       evt
);
    logic prev_q;
    logic evt_q;
    logic rise, fall, hit;

    // Transition classification against the previous sample, per selected mode.
    always_comb begin
        rise = !prev_q &&  sample;
        fall =  prev_q && !sample;
        unique case (edge_mode_e'(mode))
            MODE_RISE: hit = rise;
            MODE_FALL: hit = fall;
            MODE_BOTH: hit = rise || fall;
            default:   hit = 1'b0;
        endcase
    end

    // Previous sample always follows the line; the event is gated by enable and mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            evt_q  <= 1'b0;
        end else begin
            prev_q <= sample;
            evt_q  <= hit && det_en && !mask_bit;
        end
    end

    assign evt = evt_q;

    // R5: a line in the reserved mode never fires.
    a_r5_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |-> ($past(mode) != MODE_RSVD));
    // R6: a masked line never fires.
    a_r6_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |-> !$past(mask_bit));
    // R7: no event while detection is disabled.
    a_r7_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |-> $past(det_en));
    // R10: every event comes from a real change between consecutive samples.
    a_r10_change_needed: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |-> ($past(sample) != $past(prev_q)));

endmodule

// File: rtl/edet_line_array.sv
// Line array: one cell per monitored line. Each cell gets its 2-bit mode slice and its mask bit.
// Assumes mode_flat holds line i at bits [2i+1:2i].
module edet_line_array #(
    parameter int NUM_LINES = 256
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_LINES-1:0]   mon_in,
    input  logic [2*NUM_LINES-1:0] mode_flat,
    input  logic [NUM_LINES-1:0]   mask_flat,
    input  logic                   det_en,
    output logic [NUM_LINES-1:0]   evt_out
);
    generate
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
            edet_line_cell u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .sample   (mon_in[i]),
                .mode     (mode_flat[2*i +: 2]),
                .mask_bit (mask_flat[i]),
                .det_en   (det_en),
                .evt      (evt_out[i])
            );
        end
    endgenerate
endmodule

// File: rtl/edet_top.sv
// Top: programmable multi-line edge detector. It joins the register bank to the line array.
// Assumes all inputs are synchronous to clk and reset is synchronous, active low.
module edet_top #(
    parameter int NUM_LINES = 256,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    input  logic                 reg_we,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [NUM_LINES-1:0] mon_in,
    output logic [NUM_LINES-1:0] evt_out
);
    logic [2*NUM_LINES-1:0] mode_flat;
    logic [NUM_LINES-1:0]   mask_flat;
    logic                   det_en;

    edet_regbank #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .mode_flat (mode_flat),
        .mask_flat (mask_flat),
        .det_en    (det_en)
    );

    edet_line_array #(.NUM_LINES(NUM_LINES)) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .mon_in    (mon_in),
        .mode_flat (mode_flat),
        .mask_flat (mask_flat),
        .det_en    (det_en),
        .evt_out   (evt_out)
    );
endmodule

// File: tb/edet_top_test.sv
// Bench: a behavioural model updated every cycle and compared on every clock.
module edet_top_test;
    logic         clk = 1'b0;
    logic         rst_n;
    logic [11:0]  reg_addr;
    logic [31:0]  reg_wdata;
    logic         reg_we;
    logic [31:0]  reg_rdata;
    logic [255:0] mon_in;
    logic [255:0] evt_out;

    edet_top uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .mon_in(mon_in), .evt_out(evt_out)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0]  m_ctrl [16];
    logic [31:0]  m_mask [8];
    logic         m_en;
    logic [255:0] m_prev;
    string ev_tag = "R1";
    string rd_tag = "R1";

    task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [11:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        if (a == 12'h780) return {31'h0, m_en};
        if (a >= 12'h808 && a < 12'h848) return m_ctrl[(a - 12'h808) >> 2];
        if (a >= 12'h848 && a < 12'h868) return m_mask[(a - 12'h848) >> 2];
        return 32'h0;
    endfunction

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        if (a[1:0] != 2'b00) return;
        if (a == 12'h780) m_en = d[0];
        else if (a >= 12'h808 && a < 12'h848) m_ctrl[(a - 12'h808) >> 2] = d;
        else if (a >= 12'h848 && a < 12'h868) m_mask[(a - 12'h848) >> 2] = d;
    endtask

    function automatic logic [255:0] model_events(input logic [255:0] cur);
        logic [255:0] e = '0;
        for (int i = 0; i < 256; i++) begin
            int md = (m_ctrl[i / 16] >> (2 * (i % 16))) & 3;
            bit up = !m_prev[i] && cur[i];
            bit dn = m_prev[i] && !cur[i];
            bit f = (md == 0) ? up : (md == 1) ? dn : (md == 2) ? (up || dn) : 1'b0;
            e[i] = f && m_en && !m_mask[i / 32][i % 32];
        end
        return e;
    endfunction

    // One cycle: apply at a falling edge, predict, then check at the next falling edge.
    task automatic step(input logic [255:0] m, input logic we, input logic [11:0] a, input logic [31:0] d);
        logic [255:0] exp_ev;
        logic [31:0]  exp_rd;
        mon_in = m; reg_we = we; reg_addr = a; reg_wdata = d;
        exp_ev = model_events(m);
        exp_rd = model_read(a);
        if (we) model_write(a, d);
        m_prev = m;
        @(posedge clk);
        @(negedge clk);
        chk(evt_out == exp_ev, ev_tag, evt_out, exp_ev);
        chk(reg_rdata == exp_rd, rd_tag, {224'h0, reg_rdata}, {224'h0, exp_rd});
    endtask

    function automatic logic [255:0] rnd256();
        return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        step(m_prev, 1'b1, a, d);
    endtask

    task automatic rd(input logic [11:0] a);
        step(m_prev, 1'b0, a, 32'h0);
    endtask

    task automatic all_ctrl(input logic [31:0] d);
        for (int n = 0; n < 16; n++) wr(12'h808 + 12'(4 * n), d);
    endtask

    task automatic burst(input int cycles);
        for (int k = 0; k < cycles; k++) step(rnd256(), 1'b0, 12'h000, 32'h0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; mon_in = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        for (int n = 0; n < 16; n++) m_ctrl[n] = '0;
        for (int n = 0; n < 8; n++) m_mask[n] = '0;
        m_en = 1'b0; m_prev = '0;
        repeat (3) @(negedge clk);
        // R1: reset state of outputs
        chk(evt_out == '0, "R1", evt_out, '0);
        chk(reg_rdata == '0, "R1", {224'h0, reg_rdata}, '0);
        rst_n = 1'b1;
        // R1: registers read back as zero
        rd(12'h780); rd(12'h808); rd(12'h844); rd(12'h848); rd(12'h864);

        // R2: rising mode everywhere
        ev_tag = "R2"; rd_tag = "R8";
        wr(12'h780, 32'h1);
        step('0, 1'b0, 12'h0, 32'h0);
        step('1, 1'b0, 12'h0, 32'h0);
        step('0, 1'b0, 12'h0, 32'h0);
        burst(20);

        // R3: falling mode
        ev_tag = "R3";
        all_ctrl(32'h5555_5555);
        step('1, 1'b0, 12'h0, 32'h0);
        step('0, 1'b0, 12'h0, 32'h0);
        burst(20);

        // R4: both edges
        ev_tag = "R4";
        all_ctrl(32'hAAAA_AAAA);
        burst(20);

        // R5: reserved code
        ev_tag = "R5";
        all_ctrl(32'hFFFF_FFFF);
        burst(20);

        // R6: mixed modes with random masks
        ev_tag = "R6";
        for (int n = 0; n < 16; n++) wr(12'h808 + 12'(4 * n), $urandom);
        for (int n = 0; n < 8; n++) wr(12'h848 + 12'(4 * n), $urandom);
        burst(30);
        for (int n = 0; n < 8; n++) wr(12'h848 + 12'(4 * n), 32'hFFFF_FFFF);
        burst(10);
        for (int n = 0; n < 8; n++) wr(12'h848 + 12'(4 * n), 32'h0);

        // R7: disable, changes while off, then re-enable with steady lines
        ev_tag = "R7";
        all_ctrl(32'hAAAA_AAAA);
        wr(12'h780, 32'hFFFF_FFFE);
        rd(12'h780);
        burst(10);
        step(~m_prev, 1'b0, 12'h0, 32'h0);
        wr(12'h780, 32'h1);
        rd(12'h780);
        step(m_prev, 1'b0, 12'h0, 32'h0);

        // R8: read back every word
        ev_tag = "R8"; rd_tag = "R8";
        for (int n = 0; n < 16; n++) wr(12'h808 + 12'(4 * n), $urandom);
        for (int n = 0; n < 8; n++) wr(12'h848 + 12'(4 * n), $urandom);
        for (int n = 0; n < 16; n++) rd(12'h808 + 12'(4 * n));
        for (int n = 0; n < 8; n++) rd(12'h848 + 12'(4 * n));
        rd(12'h780);

        // R9: unmapped and misaligned accesses
        ev_tag = "R9"; rd_tag = "R9";
        wr(12'h800, 32'hFFFF_FFFF); wr(12'h804, 32'hFFFF_FFFF);
        wr(12'h868, 32'hFFFF_FFFF); wr(12'h000, 32'hFFFF_FFFF);
        wr(12'h809, 32'hFFFF_FFFF); wr(12'h84A, 32'hFFFF_FFFF);
        wr(12'h781, 32'h0); wr(12'hFFC, 32'hFFFF_FFFF);
        rd(12'h800); rd(12'h868); rd(12'h809); rd(12'h84A); rd(12'hFFC); rd(12'h781);
        for (int n = 0; n < 16; n++) rd(12'h808 + 12'(4 * n));
        for (int n = 0; n < 8; n++) rd(12'h848 + 12'(4 * n));
        rd(12'h780);
        burst(10);

        // R10: held level after a single edge gives one pulse only
        ev_tag = "R10"; rd_tag = "R10";
        all_ctrl(32'h0);
        for (int n = 0; n < 8; n++) wr(12'h848 + 12'(4 * n), 32'h0);
        step('0, 1'b0, 12'h0, 32'h0);
        step('1, 1'b0, 12'h0, 32'h0);
        repeat (5) step('1, 1'b0, 12'h0, 32'h0);
        all_ctrl(32'hAAAA_AAAA);
        step('0, 1'b0, 12'h0, 32'h0);
        repeat (5) step('0, 1'b0, 12'h0, 32'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule